// File: doc/BRIEF.md
# Protection region register file

This block is the software-visible configuration store for a bank of memory protection regions. Software programs it through a simple word-addressed read/write port that completes in one cycle. Each region holds a base address and an attribute word. The attribute word carries execute-never, access permission, memory type, shareable, cacheable and bufferable flags, a subregion-disable byte, a size code and a per-region enable. A global control word switches checking on, extends it to fault and NMI handlers, and lets privileged code fall back to the default map. All of this is exported as flat vectors to a separate permission checker.

Region base and attribute registers are windows onto one region, chosen by a selector register. A base write with its valid flag set carries its own 4-bit region number. That number becomes the new selector before the address is stored. The base/attribute pair is repeated at three further consecutive word addresses. Software can therefore stream alternating base/attribute words in one burst and program four regions without touching the selector.

Word address map (the order matters for streaming): 0 identity word, 1 control, 2 region selector, 3/4 primary base/attribute, 5/6, 7/8 and 9/10 the three repeats of that pair. All other addresses are unmapped.

Top module: `prot_regfile`

## Requirements
- R1: After reset the control word, the selector and every region's base and attribute are zero; the identity word still reads its constant.
- R2: Address 0 reads the number of regions in bits [15:8] and zero in every other bit; writes to it have no effect.
- R3: Address 1 keeps bits [2:0] of a write (bit 0 global enable, bit 1 handler checking, bit 2 privileged default-map background), drives them onto the three control outputs and reads zero in bits [31:3].
- R4: Address 2 stores only the low 4 bits of a written value as the selected region index and reads it back zero-extended.
- R5: A base write with bit 4 (valid) set first makes bits [3:0] of the data the selected region, then stores data bits [31:5] as that region's base address.
- R6: A base write with bit 4 clear stores data bits [31:5] into the currently selected region and leaves the selector unchanged.
- R7: A base read returns the selected region's address in bits [31:5], 0 in bit 4 and the selector in bits [3:0].
- R8: An attribute write stores only bits 28, [26:24], [21:16], [15:8] and [5:0] (enable in bit 0) for the selected region; an attribute read returns them with every other bit zero.
- R9: Writing zero to an attribute address disables the selected region (its exported enable, attribute bit 0, goes low).
- R10: Addresses 5/6, 7/8 and 9/10 behave exactly as 3/4, so eight consecutive writes with valid set program four regions.
- R11: Unmapped addresses (11 to 15) read zero and writes to them change no state.
- R12: The exported control bits and per-region base and attribute vectors equal the stored configuration in every cycle, region i at bits [i*27 +: 27] and [i*32 +: 32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe, zero otherwise |
| prot_enable | output | 1 | Global checking enable |
| prot_in_handlers | output | 1 | Checking also applies to fault/NMI handlers |
| prot_priv_background | output | 1 | Default map serves as privileged background region |
| region_base_o | output | NUM_REGIONS*27 | Per-region base address bits [31:5] |
| region_attr_o | output | NUM_REGIONS*32 | Per-region attribute words |

## Verification
On every cycle the assertions watch the selector side effects of base writes (valid set loads it, valid clear keeps it). They also check that a zero attribute write switches the region off on the next cycle, and that reserved read bits, the identity word, the base readback format and unmapped reads are zero where they must be. Which region a write actually landed in, the masking of large selector values, and the four-region streaming burst through the repeated addresses can only be shown by the bench. It does so by comparing the exported vectors against its own model after each scripted sequence.

// File: rtl/prot_regs_pkg.sv
package prot_regs_pkg;

  localparam int WORD_W   = 32;
  localparam int BASE_LSB = 5;
  localparam int BASE_W   = WORD_W - BASE_LSB;
  localparam int RFLD_W   = 4;
  localparam int CTRL_W   = 3;
  localparam int VALID_B  = 4;

  // bits kept in an attribute word: 28, 26:24, 21:16, 15:8, 5:0
  localparam logic [WORD_W-1:0] ATTR_KEEP = 32'h173F_FF3F;

  typedef enum logic [2:0] {
    RC_IDENT,
    RC_CTRL,
    RC_SEL,
    RC_BASE,
    RC_ATTR,
    RC_NONE
  } reg_cls_e;

  // word address -> register class; pairs = number of repeated base/attr pairs
  function automatic reg_cls_e classify(logic [7:0] a, int pairs);
    reg_cls_e c;
    if (a == 8'd0)      c = RC_IDENT;
    else if (a == 8'd1) c = RC_CTRL;
    else if (a == 8'd2) c = RC_SEL;
    else if (a < 8'(3 + 2 * (pairs + 1))) c = a[0] ? RC_BASE : RC_ATTR;
    else                c = RC_NONE;
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ident_word(int nreg);
    return {16'd0, 8'(nreg), 8'd0};
  endfunction

  function automatic logic [WORD_W-1:0] base_readback(logic [BASE_W-1:0] adr,
                                                      logic [RFLD_W-1:0] idx);
    return {adr, 1'b0, idx};
  endfunction

endpackage

// File: rtl/prot_decode.sv
module prot_decode
  import prot_regs_pkg::*;
#(
  parameter int BUS_AW      = 4,
  parameter int ALIAS_PAIRS = 3
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  output reg_cls_e          cls,
  output logic              rd_en,
  output logic              wr_ctrl,
  output logic              wr_sel,
  output logic              wr_base,
  output logic              wr_attr
);
  logic wr_en;

  always_comb begin
    cls     = classify(8'(bus_addr), ALIAS_PAIRS);
    wr_en   = bus_sel & bus_wr;
    rd_en   = bus_sel & ~bus_wr;
    wr_ctrl = wr_en & (cls == RC_CTRL);
    wr_sel  = wr_en & (cls == RC_SEL);
    wr_base = wr_en & (cls == RC_BASE);
    wr_attr = wr_en & (cls == RC_ATTR);
  end
endmodule

// File: rtl/prot_region_bank.sv
module prot_region_bank
  import prot_regs_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int IDX_W       = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          base_we,
  input  logic                          attr_we,
  input  logic [IDX_W-1:0]              tgt_idx,
  input  logic [WORD_W-1:0]             wdata,
  output logic [NUM_REGIONS*BASE_W-1:0] base_flat,
  output logic [NUM_REGIONS*WORD_W-1:0] attr_flat
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic             hit;
    logic [BASE_W-1:0] base_q;
    logic [WORD_W-1:0] attr_q;

    assign hit = (tgt_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        attr_q <= '0;
      end else begin
        if (base_we && hit) base_q <= wdata[WORD_W-1:BASE_LSB];
        if (attr_we && hit) attr_q <= wdata & ATTR_KEEP;
      end
    end

    assign base_flat[g*BASE_W +: BASE_W] = base_q;
    assign attr_flat[g*WORD_W +: WORD_W] = attr_q;
  end
endmodule

// File: rtl/prot_read_mux.sv
module prot_read_mux
  import prot_regs_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int IDX_W       = 4
) (
  input  logic                          rd_en,
  input  reg_cls_e                      cls,
  input  logic [CTRL_W-1:0]             ctrl,
  input  logic [IDX_W-1:0]              sel_idx,
  input  logic [NUM_REGIONS*BASE_W-1:0] base_flat,
  input  logic [NUM_REGIONS*WORD_W-1:0] attr_flat,
  output logic [WORD_W-1:0]             rdata
);
  logic [BASE_W-1:0] cur_base;
  logic [WORD_W-1:0] cur_attr;

  assign cur_base = base_flat[sel_idx*BASE_W +: BASE_W];
  assign cur_attr = attr_flat[sel_idx*WORD_W +: WORD_W];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (cls)
        RC_IDENT: rdata = ident_word(NUM_REGIONS);
        RC_CTRL:  rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl};
        RC_SEL:   rdata = WORD_W'(sel_idx);
        RC_BASE:  rdata = base_readback(cur_base, RFLD_W'(sel_idx));
        RC_ATTR:  rdata = cur_attr;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/prot_regfile.sv
module prot_regfile
  import prot_regs_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ALIAS_PAIRS = 3,
  parameter int BUS_AW      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [BUS_AW-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          prot_enable,
  output logic                          prot_in_handlers,
  output logic                          prot_priv_background,
  output logic [NUM_REGIONS*27-1:0]     region_base_o,
  output logic [NUM_REGIONS*32-1:0]     region_attr_o
);
  localparam int IDX_W = $clog2(NUM_REGIONS);

  reg_cls_e          cls;
  logic              rd_en, wr_ctrl, wr_sel, wr_base, wr_attr;
  logic [CTRL_W-1:0] ctrl_q;
  logic [IDX_W-1:0]  sel_q;
  logic [IDX_W-1:0]  tgt_idx;
  logic              base_picks_region;   // named event for the checker
  logic [NUM_REGIONS-1:0] region_on;      // per-region enable, for the checker

  prot_decode #(.BUS_AW(BUS_AW), .ALIAS_PAIRS(ALIAS_PAIRS)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .cls     (cls),
    .rd_en   (rd_en),
    .wr_ctrl (wr_ctrl),
    .wr_sel  (wr_sel),
    .wr_base (wr_base),
    .wr_attr (wr_attr)
  );

  assign base_picks_region = wr_base & bus_wdata[VALID_B];
  assign tgt_idx = base_picks_region ? bus_wdata[IDX_W-1:0] : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_sel || base_picks_region) sel_q <= bus_wdata[IDX_W-1:0];
    end
  end

  prot_region_bank #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_we  (wr_base),
    .attr_we  (wr_attr),
    .tgt_idx  (tgt_idx),
    .wdata    (bus_wdata),
    .base_flat(region_base_o),
    .attr_flat(region_attr_o)
  );

  prot_read_mux #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_rmux (
    .rd_en    (rd_en),
    .cls      (cls),
    .ctrl     (ctrl_q),
    .sel_idx  (sel_q),
    .base_flat(region_base_o),
    .attr_flat(region_attr_o),
    .rdata    (bus_rdata)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_on
    assign region_on[g] = region_attr_o[g*WORD_W];
  end

  assign prot_enable          = ctrl_q[0];
  assign prot_in_handlers     = ctrl_q[1];
  assign prot_priv_background = ctrl_q[2];
endmodule

// File: rtl/prot_regfile_chk.sv
module prot_regfile_chk
  import prot_regs_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ALIAS_PAIRS = 3,
  parameter int BUS_AW      = 4,
  parameter int IDX_W       = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [BUS_AW-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [IDX_W-1:0]       cur_idx,
  input logic                   wr_base,
  input logic                   wr_attr,
  input logic [NUM_REGIONS-1:0] region_on
);
  reg_cls_e c;
  logic     rd;
  assign c  = classify(8'(bus_addr), ALIAS_PAIRS);
  assign rd = bus_sel & ~bus_wr;

  AST_IDENT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && c == RC_IDENT) |-> bus_rdata == ident_word(NUM_REGIONS)); // R2
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && c == RC_CTRL) |-> bus_rdata[31:3] == '0); // R3
  AST_VALID_LOADS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && bus_wdata[4]) |=> cur_idx == $past(bus_wdata[IDX_W-1:0])); // R5
  AST_PLAIN_BASE_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && !bus_wdata[4]) |=> $stable(cur_idx)); // R6
  AST_BASE_READ_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && c == RC_BASE) |-> (bus_rdata[4] == 1'b0 && bus_rdata[3:0] == 4'(cur_idx))); // R7
  AST_ATTR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && c == RC_ATTR) |-> (bus_rdata & ~ATTR_KEEP) == '0); // R8
  AST_ZERO_ATTR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_attr && bus_wdata == '0) |=> !region_on[$past(cur_idx)]); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && c == RC_NONE) |-> bus_rdata == '0); // R11
endmodule

bind prot_regfile prot_regfile_chk #(
  .NUM_REGIONS(NUM_REGIONS), .ALIAS_PAIRS(ALIAS_PAIRS), .BUS_AW(BUS_AW), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .cur_idx  (sel_q),
  .wr_base  (wr_base),
  .wr_attr  (wr_attr),
  .region_on(region_on)
);

// File: tb/prot_regfile_bench.sv
module prot_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        prot_enable, prot_in_handlers, prot_priv_background;
  logic [NREG*27-1:0] region_base_o;
  logic [NREG*32-1:0] region_attr_o;

  int tests = 0, fails = 0;
  bit live = 0;

  // behavioural model
  logic [31:0] m_base[NREG];   // full address word, low 5 bits zero
  logic [31:0] m_attr[NREG];
  int          m_sel;
  logic [2:0]  m_ctrl;

  prot_regfile u_prot_regfile (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prot_enable(prot_enable), .prot_in_handlers(prot_in_handlers),
    .prot_priv_background(prot_priv_background),
    .region_base_o(region_base_o), .region_attr_o(region_attr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NREG; i++) begin m_base[i] = '0; m_attr[i] = '0; end
    m_sel = 0; m_ctrl = '0;
  endfunction

  function automatic void model_write(int a, logic [31:0] d);
    if (a == 1) m_ctrl = d[2:0];
    else if (a == 2) m_sel = int'(d[3:0]);
    else if (a inside {3, 5, 7, 9}) begin
      if (d[4]) m_sel = int'(d[3:0]);
      m_base[m_sel] = {d[31:5], 5'b0};
    end else if (a inside {4, 6, 8, 10}) begin
      m_attr[m_sel] = d & {3'b0, 1'b1, 1'b0, 3'b111, 2'b0, 6'h3F, 8'hFF, 2'b0, 6'h3F};
    end
  endfunction

  function automatic logic [31:0] model_read(int a);
    if (a == 0) return 32'(NREG) << 8;
    if (a == 1) return {29'b0, m_ctrl};
    if (a == 2) return 32'(m_sel);
    if (a inside {3, 5, 7, 9}) return m_base[m_sel] | 32'(m_sel);
    if (a inside {4, 6, 8, 10}) return m_attr[m_sel];
    return '0;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(posedge clk);
    #1 model_write(a, d);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 4'(a); bus_wdata = '0;
    #1 check(req, bus_rdata, model_read(a));
    @(posedge clk);
    #1 bus_sel = 0;
  endtask

  task automatic rd_exp(int a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 4'(a);
    #1 check(req, bus_rdata, exp);
    @(posedge clk);
    #1 bus_sel = 0;
  endtask

  // R12: compare exported state against the model every cycle
  always @(negedge clk) begin
    if (live) begin
      bit bad = 0;
      for (int i = 0; i < NREG; i++) begin
        if (region_base_o[i*27 +: 27] !== m_base[i][31:5]) bad = 1;
        if (region_attr_o[i*32 +: 32] !== m_attr[i]) bad = 1;
      end
      check("R12 ctrl outputs", {29'b0, prot_priv_background, prot_in_handlers, prot_enable},
            {29'b0, m_ctrl});
      check("R12 region vectors", {31'b0, bad}, 32'b0);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;

    // R1 reset state
    rd(1, "R1 ctrl after reset");
    rd(2, "R1 selector after reset");
    rd(3, "R1 base after reset");
    rd(4, "R1 attr after reset");
    rd_exp(0, 32'h0000_1000, "R1 ident after reset");

    // R2 identity word, writes ignored
    wr(0, 32'hFFFF_FFFF);
    rd_exp(0, 32'h0000_1000, "R2 ident after write");

    // R3 control
    wr(1, 32'hFFFF_FFFD);
    rd_exp(1, 32'h0000_0005, "R3 ctrl readback");
    wr(1, 32'h0000_0002);
    rd(1, "R3 ctrl handler bit");

    // R4 selector masked to 4 bits
    wr(2, 32'h0000_0025);
    rd_exp(2, 32'h0000_0005, "R4 selector masked");

    // R5 base with valid selects region
    wr(3, 32'h0800_0000 | 32'h10 | 32'd12);
    rd_exp(2, 32'd12, "R5 selector from base write");
    rd_exp(3, 32'h0800_000C, "R5 R7 base readback");

    // R6 base with valid clear keeps selector
    wr(3, 32'h2000_0007);
    rd_exp(2, 32'd12, "R6 selector kept");
    rd_exp(3, 32'h2000_000C, "R6 base updated in selected region");

    // R8 attribute masking
    wr(4, 32'hFFFF_FFFF);
    rd_exp(4, 32'h173F_FF3F, "R8 attr reserved bits zero");

    // R9 zero write disables
    wr(4, 32'h0);
    rd_exp(4, 32'h0, "R9 attr cleared");

    // R10 streaming burst through the repeated pairs
    wr(3,  32'h0800_0000 | 32'h10 | 32'd8);
    wr(4,  32'h0313_0027);
    wr(5,  32'h2000_0000 | 32'h10 | 32'd9);
    wr(6,  32'h1303_001D);
    wr(7,  32'h4002_0000 | 32'h10 | 32'd10);
    wr(8,  32'h1310_0019);
    wr(9,  32'h4002_2000 | 32'h10 | 32'd11);
    wr(10, 32'h1310_C017);
    rd_exp(2, 32'd11, "R10 selector after burst");
    rd_exp(10, 32'h1310_C017, "R10 last alias attr");
    wr(2, 32'd9);
    rd_exp(6, 32'h1303_001D, "R10 alias attr region 9");
    rd_exp(5, 32'h2000_0009, "R10 alias base region 9");
    wr(7, 32'h3000_0001);   // alias, valid clear
    rd_exp(3, 32'h3000_0009, "R10 R6 alias plain base");

    // R11 unmapped
    wr(12, 32'hFFFF_FFFF);
    wr(15, 32'h1234_5678);
    rd_exp(12, 32'h0, "R11 unmapped read");
    rd(2, "R11 selector untouched");
    rd(1, "R11 ctrl untouched");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule